// File: doc/BRIEF.md
# Indexed Host Register Port With Sequential Memory Window

This block is the host-facing slave of a larger device. A host reaches it through one active-low select, one port-select pin and a 16-bit data bus. Only two ports are visible. With the port-select pin low, the host reaches an 8-bit index register. With the pin high, the host reaches whatever internal location the index currently names. The host must therefore load the index before it touches any register. Accesses are synchronous strobes sampled on the clock edge. Each read returns its data one cycle later, marked by a valid pulse.

Besides a small bank of general registers, some index values open a window onto an internal byte memory. Separate read and write pointers, each split into a low and a high byte, set where a burst starts. Memory reads pass through a prefetch buffer. A read command returns the buffer as it stood before the edge, then refills the buffer from the read pointer and advances the pointer. The first read after the pointer is set is therefore a dummy that the host discards. A mode input chooses 8-bit or 16-bit transfers, and the pointer step follows the mode.

Top module: `idx_host_port`

## Requirements
- R1: With cs_n high, or with rd_en and wr_en both high, an access has no effect: the index, the registers and the pointers keep their values and rvalid stays low.
- R2: A write with cmd=0 loads wdata[7:0] into the index. A read with cmd=0 returns the index zero-extended.
- R3: With cmd=1 and index below REG_COUNT (16), a write stores wdata[7:0] into that register and a read returns it zero-extended. For any other index without a function, reads return 0 and writes are ignored.
- R4: Index 0xE0/0xE1 is the read pointer low/high byte, and 0xE2/0xE3 is the write pointer low/high byte. All four can be written and read back. The high byte holds only pointer bits 8 and up, and its other bits read 0.
- R5: A read at index 0xE8 returns the prefetch buffer as it was before the edge. In the same edge the buffer is refilled from the read pointer and the pointer advances. So the first read after the pointer is set returns stale data. The buffer changes only on such reads, and memory writes to the buffered location do not change it.
- R6: A write at index 0xEC stores data at the write pointer and advances the pointer. In byte mode it stores wdata[7:0]. In word mode it stores the low byte at the pointer and the high byte at pointer+1.
- R7: With word_mode=0, the pointers step by 1 and every read returns rdata[15:8]=0. With word_mode=1, the pointers step by 2 and a prefetch loads {mem[p+1], mem[p]}.
- R8: Memory addresses and both pointers wrap modulo MEM_BYTES (512). This includes the upper byte of a word at address 511, which is taken from address 0.
- R9: After reset, rdata=0 and rvalid=0. rvalid is high for exactly the one cycle after each accepted read, and rdata holds its value between reads.
- R10: A read at index 0xEC returns 0. A write at index 0xE8 is ignored: neither pointer moves and the memory is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select |
| cmd | input | 1 | Port select: 0 index port, 1 data port |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| word_mode | input | 1 | 1 = 16-bit transfers, 0 = 8-bit |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid with rvalid |
| rvalid | output | 1 | One-cycle read-data valid |

## Verification
On one edge, a memory-window read both hands out the prefetch buffer and refills it. The bench checks that the returned word is always the value loaded by the previous read and never the freshly fetched one: byte and word bursts each start with a dummy whose value the bench predicts from its own model. A second case writes a new value into the very location that is already sitting in the buffer. The bench expects the next read to return the old value, and only a fresh dummy and read to return the new one.

// File: rtl/idx_host_pkg.sv
package idx_host_pkg;

  localparam int unsigned IDX_W  = 8;
  localparam int unsigned DATA_W = 16;

  // Indices with a dedicated function (above the general register bank)
  localparam logic [IDX_W-1:0] IDX_RPTR_LO = 8'hE0;
  localparam logic [IDX_W-1:0] IDX_RPTR_HI = 8'hE1;
  localparam logic [IDX_W-1:0] IDX_WPTR_LO = 8'hE2;
  localparam logic [IDX_W-1:0] IDX_WPTR_HI = 8'hE3;
  localparam logic [IDX_W-1:0] IDX_MEM_RD  = 8'hE8;
  localparam logic [IDX_W-1:0] IDX_MEM_WR  = 8'hEC;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_INDEX,
    SEL_REG,
    SEL_RPTR_LO,
    SEL_RPTR_HI,
    SEL_WPTR_LO,
    SEL_WPTR_HI,
    SEL_MEMBUF
  } rd_sel_e;

  typedef struct packed {
    logic idx_we;
    logic reg_we;
    logic rlo_we;
    logic rhi_we;
    logic wlo_we;
    logic whi_we;
    logic mem_wr;
    logic mem_rd;
    logic rd_go;
  } host_op_t;

endpackage

// File: rtl/idx_host_decode.sv
module idx_host_decode
  import idx_host_pkg::*;
#(
  parameter int unsigned REG_COUNT = 16
) (
  input  logic             cs_n,
  input  logic             cmd,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  output host_op_t         op,
  output rd_sel_e          sel
);

  localparam logic [IDX_W-1:0] REG_LIM = IDX_W'(REG_COUNT);

  logic wr_go;
  logic rd_go;

  assign wr_go = !cs_n && wr_en && !rd_en;
  assign rd_go = !cs_n && rd_en && !wr_en;

  always_comb begin
    op       = '0;
    sel      = SEL_NONE;
    op.rd_go = rd_go;
    if (!cmd) begin
      op.idx_we = wr_go;
      if (rd_go) sel = SEL_INDEX;
    end else if (idx < REG_LIM) begin
      op.reg_we = wr_go;
      if (rd_go) sel = SEL_REG;
    end else begin
      unique case (idx)
        IDX_RPTR_LO: begin op.rlo_we = wr_go; if (rd_go) sel = SEL_RPTR_LO; end
        IDX_RPTR_HI: begin op.rhi_we = wr_go; if (rd_go) sel = SEL_RPTR_HI; end
        IDX_WPTR_LO: begin op.wlo_we = wr_go; if (rd_go) sel = SEL_WPTR_LO; end
        IDX_WPTR_HI: begin op.whi_we = wr_go; if (rd_go) sel = SEL_WPTR_HI; end
        IDX_MEM_RD:  begin op.mem_rd = rd_go; if (rd_go) sel = SEL_MEMBUF;  end
        IDX_MEM_WR:  begin op.mem_wr = wr_go; end
        default:     ;
      endcase
    end
  end

endmodule

// File: rtl/idx_host_regfile.sv
module idx_host_regfile #(
  parameter int unsigned REG_COUNT = 16,
  localparam int unsigned RAW      = $clog2(REG_COUNT)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [RAW-1:0] sel_idx,
  input  logic [7:0]     wdata,
  output logic [7:0]     rdata
);

  logic [7:0] regs_q [REG_COUNT];

  for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
    logic en;
    assign en = we && (sel_idx == RAW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  regs_q[g] <= '0;
      else if (en) regs_q[g] <= wdata;
    end
  end

  assign rdata = regs_q[sel_idx];

endmodule

// File: rtl/idx_host_memport.sv
module idx_host_memport #(
  parameter int unsigned MEM_BYTES = 512,
  localparam int unsigned AW       = $clog2(MEM_BYTES),
  localparam int unsigned HI_W     = AW - 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          word_mode,
  input  logic          rlo_we,
  input  logic          rhi_we,
  input  logic          wlo_we,
  input  logic          whi_we,
  input  logic          mem_wr,
  input  logic          mem_rd,
  input  logic [15:0]   wdata,
  output logic [AW-1:0] rd_ptr,
  output logic [AW-1:0] wr_ptr,
  output logic [15:0]   buf_q
);

  logic [7:0]    mem_q [MEM_BYTES];
  logic [AW-1:0] rd_ptr_q, rd_ptr_d;
  logic [AW-1:0] wr_ptr_q, wr_ptr_d;
  logic [15:0]   buf_d;
  logic [AW-1:0] step;
  logic [AW-1:0] rd_hi_addr;
  logic [AW-1:0] wr_hi_addr;

  assign step       = word_mode ? AW'(2) : AW'(1);
  assign rd_hi_addr = rd_ptr_q + AW'(1);
  assign wr_hi_addr = wr_ptr_q + AW'(1);

  // Next-state
  always_comb begin
    rd_ptr_d = rd_ptr_q;
    if (rlo_we)      rd_ptr_d = {rd_ptr_q[AW-1:8], wdata[7:0]};
    else if (rhi_we) rd_ptr_d = {wdata[HI_W-1:0], rd_ptr_q[7:0]};
    else if (mem_rd) rd_ptr_d = rd_ptr_q + step;

    wr_ptr_d = wr_ptr_q;
    if (wlo_we)      wr_ptr_d = {wr_ptr_q[AW-1:8], wdata[7:0]};
    else if (whi_we) wr_ptr_d = {wdata[HI_W-1:0], wr_ptr_q[7:0]};
    else if (mem_wr) wr_ptr_d = wr_ptr_q + step;

    buf_d = buf_q;
    if (mem_rd) buf_d = word_mode ? {mem_q[rd_hi_addr], mem_q[rd_ptr_q]}
                                  : {8'h00, mem_q[rd_ptr_q]};
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      buf_q    <= '0;
    end else begin
      rd_ptr_q <= rd_ptr_d;
      wr_ptr_q <= wr_ptr_d;
      buf_q    <= buf_d;
    end
  end

  // Storage array, no reset
  always_ff @(posedge clk) begin
    if (mem_wr) begin
      mem_q[wr_ptr_q] <= wdata[7:0];
      if (word_mode) mem_q[wr_hi_addr] <= wdata[15:8];
    end
  end

  assign rd_ptr = rd_ptr_q;
  assign wr_ptr = wr_ptr_q;

endmodule

// File: rtl/idx_host_port.sv
module idx_host_port
  import idx_host_pkg::*;
#(
  parameter int unsigned REG_COUNT = 16,
  parameter int unsigned MEM_BYTES = 512
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        cmd,
  input  logic        rd_en,
  input  logic        wr_en,
  input  logic        word_mode,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        rvalid
);

  localparam int unsigned AW  = $clog2(MEM_BYTES);
  localparam int unsigned RAW = $clog2(REG_COUNT);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic [IDX_W-1:0] idx_q, idx_d;
  host_op_t         op;
  rd_sel_e          sel;
  logic [7:0]       reg_rdata;
  logic [AW-1:0]    rd_ptr;
  logic [AW-1:0]    wr_ptr;
  logic [15:0]      mem_buf;
  logic [15:0]      rd_val;
  logic [15:0]      rdata_q, rdata_d;
  logic             rvalid_q, rvalid_d;

  idx_host_decode #(.REG_COUNT(REG_COUNT)) u_decode (
    .cs_n  (cs_n),
    .cmd   (cmd),
    .rd_en (rd_en),
    .wr_en (wr_en),
    .idx   (idx_q),
    .op    (op),
    .sel   (sel)
  );

  idx_host_regfile #(.REG_COUNT(REG_COUNT)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .we      (op.reg_we),
    .sel_idx (idx_q[RAW-1:0]),
    .wdata   (wdata[7:0]),
    .rdata   (reg_rdata)
  );

  idx_host_memport #(.MEM_BYTES(MEM_BYTES)) u_mem (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .word_mode (word_mode),
    .rlo_we    (op.rlo_we),
    .rhi_we    (op.rhi_we),
    .wlo_we    (op.wlo_we),
    .whi_we    (op.whi_we),
    .mem_wr    (op.mem_wr),
    .mem_rd    (op.mem_rd),
    .wdata     (wdata),
    .rd_ptr    (rd_ptr),
    .wr_ptr    (wr_ptr),
    .buf_q     (mem_buf)
  );

  // Read data selection
  always_comb begin
    unique case (sel)
      SEL_INDEX:   rd_val = {8'h00, idx_q};
      SEL_REG:     rd_val = {8'h00, reg_rdata};
      SEL_RPTR_LO: rd_val = {8'h00, rd_ptr[7:0]};
      SEL_RPTR_HI: rd_val = {8'h00, 8'(rd_ptr[AW-1:8])};
      SEL_WPTR_LO: rd_val = {8'h00, wr_ptr[7:0]};
      SEL_WPTR_HI: rd_val = {8'h00, 8'(wr_ptr[AW-1:8])};
      SEL_MEMBUF:  rd_val = mem_buf;
      default:     rd_val = '0;
    endcase
    if (!word_mode) rd_val[15:8] = 8'h00;
  end

  // Next-state
  always_comb begin
    idx_d    = op.idx_we ? wdata[7:0] : idx_q;
    rdata_d  = op.rd_go ? rd_val : rdata_q;
    rvalid_d = op.rd_go;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      idx_q    <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      idx_q    <= idx_d;
      rdata_q  <= rdata_d;
      rvalid_q <= rvalid_d;
    end
  end

  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;

endmodule

// File: rtl/idx_host_port_chk.sv
module idx_host_port_chk
  import idx_host_pkg::*;
#(
  parameter int unsigned AW = 9
) (
  input logic             clk,
  input logic             rst_n_s,
  input logic             cs_n,
  input logic             cmd,
  input logic             rd_en,
  input logic             wr_en,
  input logic             word_mode,
  input logic [15:0]      rdata,
  input logic             rvalid,
  input logic [IDX_W-1:0] idx_q,
  input logic [AW-1:0]    rd_ptr,
  input logic [AW-1:0]    wr_ptr,
  input logic [15:0]      mem_buf
);

  logic idle;
  logic rd_acc;
  logic mrd_acc;

  assign idle    = cs_n || (rd_en == wr_en);
  assign rd_acc  = !cs_n && rd_en && !wr_en;
  assign mrd_acc = rd_acc && cmd && (idx_q == IDX_MEM_RD);

  assert_idle_no_effect_R1: assert property (@(posedge clk) disable iff (!rst_n_s)
    idle |=> ($stable(idx_q) && $stable(rd_ptr) && $stable(wr_ptr) && $stable(mem_buf)));

  assert_rvalid_after_read_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    rd_acc |=> rvalid);

  assert_rvalid_only_after_read_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    !rd_acc |=> !rvalid);

  assert_rdata_holds_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    !rd_acc |=> $stable(rdata));

  assert_rdptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    mrd_acc |=> (rd_ptr == ($past(rd_ptr) + ($past(word_mode) ? AW'(2) : AW'(1)))));

  assert_mrd_returns_old_buf_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    mrd_acc |=> (rdata == ($past(word_mode) ? $past(mem_buf) : {8'h00, $past(mem_buf[7:0])})));

  assert_buf_only_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    !mrd_acc |=> $stable(mem_buf));

  assert_byte_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_acc && !word_mode) |=> (rdata[15:8] == 8'h00));

endmodule

bind idx_host_port idx_host_port_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n_s   (rst_n_s),
  .cs_n      (cs_n),
  .cmd       (cmd),
  .rd_en     (rd_en),
  .wr_en     (wr_en),
  .word_mode (word_mode),
  .rdata     (rdata),
  .rvalid    (rvalid),
  .idx_q     (idx_q),
  .rd_ptr    (rd_ptr),
  .wr_ptr    (wr_ptr),
  .mem_buf   (mem_buf)
);

// File: tb/idx_host_port_tb.sv
module idx_host_port_tb;

  localparam int CLK_PERIOD = 10;
  localparam int MEMB       = 512;
  localparam int WATCHDOG   = 50000;

  logic        clk;
  logic        rst_n;
  logic        cs_n;
  logic        cmd;
  logic        rd_en;
  logic        wr_en;
  logic        word_mode;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        rvalid;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [15:0] q_exp [$];
  string       q_tag [$];

  // Independent model of the memory window
  logic [7:0]  m_mem [MEMB];
  int          m_rp, m_wp;
  logic [15:0] m_buf;

  idx_host_port u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cmd(cmd), .rd_en(rd_en),
    .wr_en(wr_en), .word_mode(word_mode), .wdata(wdata), .rdata(rdata),
    .rvalid(rvalid)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (q_exp.size() == 0) begin
        n_checks++;
        n_fail++;
        $display("FAIL R9 unexpected rvalid act=%h exp=none", rdata);
      end else begin
        automatic logic [15:0] e = q_exp.pop_front();
        automatic string t = q_tag.pop_front();
        check(rdata, e, t);
      end
    end
  end

  task automatic acc(input logic csn, input logic c, input logic r, input logic w,
                     input logic [15:0] d);
    @(negedge clk);
    cs_n = csn; cmd = c; rd_en = r; wr_en = w; wdata = d;
    @(negedge clk);
    cs_n = 1'b1; rd_en = 1'b0; wr_en = 1'b0;
  endtask

  task automatic wr_idx(input logic [7:0] i);
    acc(1'b0, 1'b0, 1'b0, 1'b1, {8'h00, i});
  endtask

  task automatic wr_dat(input logic [15:0] d);
    acc(1'b0, 1'b1, 1'b0, 1'b1, d);
  endtask

  task automatic rd_exp(input logic c, input logic [15:0] e, input string tag);
    q_exp.push_back(e);
    q_tag.push_back(tag);
    acc(1'b0, c, 1'b1, 1'b0, 16'h0000);
  endtask

  task automatic set_rptr(input int p);
    wr_idx(8'hE1); wr_dat(16'(p >> 8));
    wr_idx(8'hE0); wr_dat(16'(p & 8'hFF));
    m_rp = p;
  endtask

  task automatic set_wptr(input int p);
    wr_idx(8'hE3); wr_dat(16'(p >> 8));
    wr_idx(8'hE2); wr_dat(16'(p & 8'hFF));
    m_wp = p;
  endtask

  // Index must already be 0xEC
  task automatic m_write(input logic [15:0] d);
    m_mem[m_wp] = d[7:0];
    if (word_mode) m_mem[(m_wp + 1) % MEMB] = d[15:8];
    m_wp = (m_wp + (word_mode ? 2 : 1)) % MEMB;
    wr_dat(d);
  endtask

  // Index must already be 0xE8
  task automatic mem_read(input string tag);
    logic [15:0] e;
    e = word_mode ? m_buf : {8'h00, m_buf[7:0]};
    m_buf = word_mode ? {m_mem[(m_rp + 1) % MEMB], m_mem[m_rp]} : {8'h00, m_mem[m_rp]};
    m_rp = (m_rp + (word_mode ? 2 : 1)) % MEMB;
    rd_exp(1'b1, e, tag);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired act=running exp=finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; cmd = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
    word_mode = 1'b0; wdata = '0;
    m_rp = 0; m_wp = 0; m_buf = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9 reset state
    check({15'b0, rvalid}, 16'h0000, "R9 rvalid after reset");
    check(rdata, 16'h0000, "R9 rdata after reset");

    // R2 index port
    rd_exp(1'b0, 16'h0000, "R2 index after reset");
    wr_idx(8'h05);
    rd_exp(1'b0, 16'h0005, "R2 index readback");

    // R3 general registers
    wr_dat(16'h12A5);
    rd_exp(1'b1, 16'h00A5, "R3 reg5 low byte only");
    wr_idx(8'h0F); wr_dat(16'h003C);
    rd_exp(1'b1, 16'h003C, "R3 reg15");
    wr_idx(8'h05);
    rd_exp(1'b1, 16'h00A5, "R3 reg5 kept");
    wr_idx(8'h40); wr_dat(16'h0077);
    rd_exp(1'b1, 16'h0000, "R3 unmapped reads zero");

    // R1 inactive and conflicting strobes
    acc(1'b1, 1'b0, 1'b0, 1'b1, 16'h0007);
    rd_exp(1'b0, 16'h0040, "R1 deselected write ignored");
    acc(1'b0, 1'b0, 1'b1, 1'b1, 16'h0009);
    rd_exp(1'b0, 16'h0040, "R1 both strobes ignored");
    acc(1'b1, 1'b0, 1'b1, 1'b0, 16'h0000);
    check({15'b0, rvalid}, 16'h0000, "R1 deselected read no rvalid");

    // Preload the memory in byte mode, full wrap of the write pointer
    set_wptr(0);
    wr_idx(8'hEC);
    for (int i = 0; i < MEMB; i++) m_write(16'((i * 37 + 11) & 8'hFF));
    wr_idx(8'hE2); rd_exp(1'b1, 16'h0000, "R8 wptr lo wrapped");
    wr_idx(8'hE3); rd_exp(1'b1, 16'h0000, "R8 wptr hi wrapped");

    // R6 byte writes
    set_wptr(16'h10);
    wr_idx(8'hEC);
    m_write(16'h0011); m_write(16'h0022); m_write(16'h0033); m_write(16'h0044);
    wr_idx(8'hE2); rd_exp(1'b1, 16'h0014, "R6 wptr step 1");

    // R6 word writes
    word_mode = 1'b1;
    set_wptr(16'h20);
    wr_idx(8'hEC);
    m_write(16'hBBAA); m_write(16'hDDCC);
    wr_idx(8'hE2); rd_exp(1'b1, 16'h0024, "R6 wptr step 2");

    // R5 byte burst with dummy first read
    word_mode = 1'b0;
    set_rptr(16'h10);
    wr_idx(8'hE8);
    mem_read("R5 byte dummy stale");
    mem_read("R5 byte read 0x10");
    mem_read("R5 byte read 0x11");
    mem_read("R5 byte read 0x12");
    wr_idx(8'hE0); rd_exp(1'b1, 16'h0014, "R5 rptr after byte burst");

    // R5/R7 word burst
    word_mode = 1'b1;
    set_rptr(16'h20);
    wr_idx(8'hE8);
    mem_read("R5 word dummy stale");
    mem_read("R7 word read 0x20");
    mem_read("R7 word read 0x22");
    wr_idx(8'hE0); rd_exp(1'b1, 16'h0026, "R7 rptr step 2");

    // R7 word-loaded buffer read in byte mode
    word_mode = 1'b0;
    wr_idx(8'hE8);
    mem_read("R7 byte mode upper zero");

    // R8 wrap in byte mode
    set_rptr(16'h1FF);
    wr_idx(8'hE8);
    mem_read("R8 byte dummy");
    mem_read("R8 byte read 0x1FF");
    mem_read("R8 byte read 0x000");
    wr_idx(8'hE1); rd_exp(1'b1, 16'h0000, "R8 rptr hi after wrap");
    wr_idx(8'hE0); rd_exp(1'b1, 16'h0002, "R8 rptr lo after wrap");

    // R8 wrap in word mode
    word_mode = 1'b1;
    set_rptr(16'h1FF);
    wr_idx(8'hE8);
    mem_read("R8 word dummy");
    mem_read("R8 word straddling end");
    wr_idx(8'hE0); rd_exp(1'b1, 16'h0003, "R8 word rptr wrap");

    // R4 pointer high byte
    word_mode = 1'b0;
    set_rptr(16'h1AB);
    wr_idx(8'hE1); rd_exp(1'b1, 16'h0001, "R4 rptr hi");
    wr_idx(8'hE0); rd_exp(1'b1, 16'h00AB, "R4 rptr lo");
    wr_idx(8'hE3); wr_dat(16'h00FF);
    m_wp = 16'h100 | (m_wp & 8'hFF);
    rd_exp(1'b1, 16'h0001, "R4 unused hi bits zero");

    // R10 wrong-direction command indices
    set_wptr(16'h24);
    set_rptr(16'h30);
    wr_idx(8'hE8);
    mem_read("R10 dummy");
    wr_dat(16'h0099);
    wr_idx(8'hEC);
    rd_exp(1'b1, 16'h0000, "R10 read of write command");
    wr_idx(8'hE0); rd_exp(1'b1, 16'h0031, "R10 rptr unmoved");
    wr_idx(8'hE2); rd_exp(1'b1, 16'h0024, "R10 wptr unmoved");
    wr_idx(8'hE8);
    mem_read("R10 buffer unchanged");

    // R5 write to the location already held in the buffer
    set_rptr(16'h40);
    wr_idx(8'hE8);
    mem_read("R5 dummy before overwrite");
    set_wptr(16'h40);
    wr_idx(8'hEC);
    m_write(16'h00E7);
    wr_idx(8'hE8);
    mem_read("R5 old value from buffer");
    set_rptr(16'h40);
    wr_idx(8'hE8);
    mem_read("R5 dummy after overwrite");
    mem_read("R6 new value landed");

    repeat (3) @(negedge clk);
    check(16'(q_exp.size()), 16'h0000, "R9 every read produced rvalid");
    done = 1;
    finish_run();
  end

endmodule